// File: doc/BRIEF.md
# Data Access Fault Classifier

This block sits beside a load/store unit and judges each data memory access in the cycle it is presented. It decides whether the access raises a trap and, if so, which one. The inputs it weighs are the access kind, the address space identifier (ASI), the virtual and physical addresses, the access size, the attributes of the translated page, and a few processor state and control bits. The five possible verdicts are misaligned address, privileged action, data access exception, data access protection and watchpoint. The address translation, the table walk and the trap vectoring are done by neighbouring logic.

Every fault, whatever its class, is logged in one shared fault status register and one fault address register. When a data access exception is reported, the status register also carries a cause bit set that names every condition that contributed to it. Software drops the valid bit of the status register through a clear strobe. A new fault that arrives while the status register is still valid sets an overwrite flag.

Top module: `dfj_fault_judge`

## Requirements
- R1: After reset, trap_valid, sfsr_valid and sfsr_ovw are 0.
- R2: The verdict for an access presented with acc_valid=1 appears on trap_valid/trap_code on the next clock edge. An idle cycle gives trap_valid=0. trap_code values: 0 none, 1 misaligned, 2 privileged action, 3 data access exception, 4 protection, 5 watchpoint. acc_kind values: 0 load, 1 store, 2 atomic, 3 flush, 4 speculative non-faulting load, 5 jump-and-link/return.
- R3: An access is misaligned when the low bits of acc_va are not a multiple of 2^acc_size bytes (acc_size 0..4 for 1 to 16 bytes), for kinds 0, 1, 2 and 4. For kind 5 the address must be a multiple of 4. Flush is never misaligned. Misaligned has the highest priority. After it, in decreasing order, come privileged action, data access exception, protection and watchpoint.
- R4: With st_priv=0, any ASI below 0x80 raises privileged action (fault type 0x01), even when that ASI is also invalid.
- R5: The valid ASIs are 0x04, 0x0C, 0x10, 0x18, 0x14, 0x15, 0x1C, 0x1D, 0x58, 0x80-0x83 and 0x88-0x8B. Any other ASI raises a data access exception with fault type bit 3 (0x08).
- R6: ASI 0x58 is register space, and acc_va must be 0x00 (read-only), 0x08 (write-only) or 0x10 (read/write). A load of 0x08, a store to 0x00, an atomic or flush, or any other address raises a data access exception with fault type bit 5 (0x20).
- R7: When mmu_on=1, an access to a page with pg_nfo=1 through a translated ASI (0x04, 0x0C, 0x10, 0x18, 0x80-0x83, 0x88-0x8B) raises a data access exception with fault type bit 1 (0x02). The exceptions are the no-fault ASIs 0x82, 0x83, 0x8A and 0x8B. Flush is included.
- R8: When mmu_on=1 and the ASI is a translated one, a virtual address whose bits 63..43 are not all equal raises a data access exception with fault type bit 4 (0x10), flush included. st_addr_mask=1 suppresses this check.
- R9: When mmu_on=0 and dp_ctl=0, a speculative load or a flush raises a data access exception with fault type bit 6 (0x40).
- R10: When mmu_on=0, an atomic access (any size, including 16 bytes) with ASI 0x15 or 0x1D raises a data access exception with fault type exactly 0x04.
- R11: When mmu_on=1, a store or atomic through a translated ASI to a page with pg_writable=0 raises protection.
- R12: A load, store, atomic or speculative load raises watchpoint when wp_va_en=1 and acc_va equals wp_va, or when wp_pa_en=1 and acc_pa equals wp_pa. Flush never raises watchpoint.
- R13: On every trap, sfsr_valid is set to 1. sfsr_ovw takes the old value of sfsr_valid. sfsr_ftype gets the cause bits: 0x01 for privileged action, the cause set for a data access exception, and 0 otherwise. sfsr_asi gets the ASI, sfsr_write is 1 for a store or atomic, and sfar gets acc_va. An access that does not trap leaves all of these unchanged.
- R14: A pulse on sfsr_clr clears sfsr_valid and sfsr_ovw. If a fault arrives in the same cycle, sfsr_valid is 1 and sfsr_ovw is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 3 | Access kind code (R2) |
| acc_size | input | 3 | log2 of the access size in bytes |
| acc_asi | input | 8 | Address space identifier |
| acc_va | input | VA_W | Virtual address |
| acc_pa | input | PA_W | Physical address |
| pg_nfo | input | 1 | Page is no-fault-only |
| pg_writable | input | 1 | Page allows writes |
| mmu_on | input | 1 | Data MMU enabled |
| st_priv | input | 1 | Processor is privileged |
| st_addr_mask | input | 1 | Address masking active |
| dp_ctl | input | 1 | Data-protection control bit |
| wp_va_en | input | 1 | Virtual watchpoint enable |
| wp_va | input | VA_W | Virtual watchpoint address |
| wp_pa_en | input | 1 | Physical watchpoint enable |
| wp_pa | input | PA_W | Physical watchpoint address |
| sfsr_clr | input | 1 | Clear the status valid and overwrite bits |
| trap_valid | output | 1 | A trap is reported |
| trap_code | output | 3 | Trap class (R2) |
| sfsr_valid | output | 1 | Fault status holds a fault |
| sfsr_ovw | output | 1 | A fault overwrote an unread one |
| sfsr_ftype | output | 7 | Fault type cause bits |
| sfsr_asi | output | 8 | ASI of the logged fault |
| sfsr_write | output | 1 | Logged fault was a write |
| sfar | output | VA_W | Address of the logged fault |

## Verification
The bench first presents clean accesses to show that no trap comes out when none is due. It then gives each fault condition alone, once with its enabling state and once with that state removed, which separates the trigger from its qualifiers: no-fault ASIs, address masking, the data-protection bit, the MMU enable and the watchpoint enables. Accesses that meet several conditions at once expose the priority chain and the OR-ing of cause bits. Back-to-back faults, faults after a clear, and a clear in the same cycle as a fault show how the overwrite bit and the register capture behave.

// File: rtl/dfj_pkg.sv
package dfj_pkg;

   typedef enum logic [2:0] {
      K_LOAD   = 3'd0,
      K_STORE  = 3'd1,
      K_ATOMIC = 3'd2,
      K_FLUSH  = 3'd3,
      K_NFLOAD = 3'd4,
      K_JMPL   = 3'd5
   } acc_kind_e;

   typedef enum logic [2:0] {
      T_NONE  = 3'd0,
      T_MIS   = 3'd1,
      T_PRIV  = 3'd2,
      T_DAE   = 3'd3,
      T_PROT  = 3'd4,
      T_WATCH = 3'd5
   } trap_e;

   localparam int FT_W = 7;

   localparam int FTB_PRIV   = 0;
   localparam int FTB_NFO    = 1;
   localparam int FTB_ATBYP  = 2;
   localparam int FTB_BADASI = 3;
   localparam int FTB_VAHOLE = 4;
   localparam int FTB_REGACC = 5;
   localparam int FTB_SPEC   = 6;

endpackage

// File: rtl/dfj_asi_dec.sv
module dfj_asi_dec #(
   parameter int          ASI_W   = 8,
   parameter logic [7:0]  REG_ASI = 8'h58
) (
   input  logic [ASI_W-1:0] asi,
   output logic             is_restricted,
   output logic             is_translated,
   output logic             is_nofault,
   output logic             is_bypass_se,
   output logic             is_regspace,
   output logic             is_valid
);

   localparam int LO_W = 8;

   initial begin
      assert (ASI_W == LO_W) else $error("dfj_asi_dec: ASI_W must be 8");
   end

   logic [LO_W-1:0] a;
   logic            is_bypass;
   assign a = LO_W'(asi);

   always_comb begin
      is_translated = 1'b0;
      is_nofault    = 1'b0;
      is_bypass     = 1'b0;
      is_bypass_se  = 1'b0;
      unique case (a)
         8'h04, 8'h0C, 8'h10, 8'h18:          is_translated = 1'b1;
         8'h80, 8'h81, 8'h88, 8'h89:          is_translated = 1'b1;
         8'h82, 8'h83, 8'h8A, 8'h8B: begin
            is_translated = 1'b1;
            is_nofault    = 1'b1;
         end
         8'h14, 8'h1C:                        is_bypass = 1'b1;
         8'h15, 8'h1D: begin
            is_bypass    = 1'b1;
            is_bypass_se = 1'b1;
         end
         default: ;
      endcase
   end

   assign is_regspace   = (a == REG_ASI);
   assign is_restricted = ~a[LO_W-1];
   assign is_valid      = is_translated | is_bypass | is_regspace;

endmodule

// File: rtl/dfj_addr_chk.sv
module dfj_addr_chk
   import dfj_pkg::*;
#(
   parameter int VA_W     = 64,
   parameter int PA_W     = 41,
   parameter int HOLE_LSB = 43,
   parameter int SZ_W     = 3,
   parameter bit PA_WATCH = 1'b1
) (
   input  acc_kind_e        kind,
   input  logic [SZ_W-1:0]  size,
   input  logic [VA_W-1:0]  va,
   input  logic [PA_W-1:0]  pa,
   input  logic             wp_va_en,
   input  logic [VA_W-1:0]  wp_va,
   input  logic             wp_pa_en,
   input  logic [PA_W-1:0]  wp_pa,
   output logic             misaligned,
   output logic             va_hole,
   output logic             wp_hit,
   output logic             reg_ro,
   output logic             reg_wo,
   output logic             reg_rw
);

   localparam int ALN_W   = 5;
   localparam int UPPER_W = VA_W - HOLE_LSB;
   localparam int OFF_W   = 8;

   initial begin
      assert (HOLE_LSB < VA_W) else $error("dfj_addr_chk: hole bit outside VA");
      assert (VA_W > OFF_W)    else $error("dfj_addr_chk: VA too narrow");
      assert (SZ_W >= 3)       else $error("dfj_addr_chk: size field too narrow");
   end

   logic [ALN_W-1:0]   amask;
   logic [UPPER_W-1:0] upper;
   logic               off_hi_zero;
   logic [OFF_W-1:0]   off;

   always_comb begin
      amask = '0;
      if (kind == K_JMPL) begin
         amask = 5'b00011;
      end else if (kind != K_FLUSH) begin
         unique case (size)
            3'd0:    amask = 5'b00000;
            3'd1:    amask = 5'b00001;
            3'd2:    amask = 5'b00011;
            3'd3:    amask = 5'b00111;
            default: amask = 5'b01111;
         endcase
      end
   end

   assign misaligned  = |(va[ALN_W-1:0] & amask);
   assign upper       = va[VA_W-1:HOLE_LSB];
   assign va_hole     = ~((&upper) | ~(|upper));
   assign off         = va[OFF_W-1:0];
   assign off_hi_zero = ~(|va[VA_W-1:OFF_W]);
   assign reg_ro      = off_hi_zero & (off == 8'h00);
   assign reg_wo      = off_hi_zero & (off == 8'h08);
   assign reg_rw      = off_hi_zero & (off == 8'h10);

   logic va_match, pa_match;
   assign va_match = wp_va_en & (va == wp_va);

   generate
      if (PA_WATCH) begin : g_pa_watch
         assign pa_match = wp_pa_en & (pa == wp_pa);
      end else begin : g_no_pa_watch
         logic unused_pa;
         assign unused_pa = ^{pa, wp_pa, wp_pa_en};
         assign pa_match  = 1'b0;
      end
   endgenerate

   assign wp_hit = va_match | pa_match;

endmodule

// File: rtl/dfj_cause.sv
module dfj_cause
   import dfj_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_valid,
   input  acc_kind_e       kind,
   input  logic            mmu_on,
   input  logic            st_priv,
   input  logic            st_addr_mask,
   input  logic            dp_ctl,
   input  logic            pg_nfo,
   input  logic            pg_writable,
   input  logic            is_restricted,
   input  logic            is_translated,
   input  logic            is_nofault,
   input  logic            is_bypass_se,
   input  logic            is_regspace,
   input  logic            is_valid,
   input  logic            misaligned,
   input  logic            va_hole,
   input  logic            wp_hit,
   input  logic            reg_ro,
   input  logic            reg_wo,
   input  logic            reg_rw,
   output logic            fire,
   output trap_e           code,
   output logic [FT_W-1:0] ftype,
   output logic            is_write
);

   logic is_data, ld_like, xlat_on, reg_bad, priv_act, prot, watch;
   logic [FT_W-1:0] dae_ft;

   assign is_data  = (kind != K_JMPL);
   assign is_write = (kind == K_STORE) | (kind == K_ATOMIC);
   assign ld_like  = (kind == K_LOAD) | (kind == K_NFLOAD);
   assign xlat_on  = is_data & mmu_on & is_translated;

   assign reg_bad = is_regspace &
                    ~((ld_like & (reg_ro | reg_rw)) |
                      ((kind == K_STORE) & (reg_wo | reg_rw)));

   always_comb begin
      dae_ft             = '0;
      dae_ft[FTB_NFO]    = xlat_on & pg_nfo & ~is_nofault;
      dae_ft[FTB_ATBYP]  = (kind == K_ATOMIC) & ~mmu_on & is_bypass_se;
      dae_ft[FTB_BADASI] = is_data & ~is_valid;
      dae_ft[FTB_VAHOLE] = xlat_on & ~st_addr_mask & va_hole;
      dae_ft[FTB_REGACC] = is_data & reg_bad;
      dae_ft[FTB_SPEC]   = ((kind == K_NFLOAD) | (kind == K_FLUSH)) & ~mmu_on & ~dp_ctl;
   end

   assign priv_act = is_data & ~st_priv & is_restricted;
   assign prot     = is_write & xlat_on & ~pg_writable;
   assign watch    = is_data & (kind != K_FLUSH) & wp_hit;

   always_comb begin
      ftype = '0;
      if (misaligned)        code = T_MIS;
      else if (priv_act) begin
         code            = T_PRIV;
         ftype[FTB_PRIV] = 1'b1;
      end else if (|dae_ft) begin
         code  = T_DAE;
         ftype = dae_ft;
      end
      else if (prot)         code = T_PROT;
      else if (watch)        code = T_WATCH;
      else                   code = T_NONE;
   end

   assign fire = acc_valid & (code != T_NONE);

   AST_DAE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && code == T_DAE) |-> (ftype != '0)); // R5

   AST_PRIV_FT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && code == T_PRIV) |-> $onehot0(ftype) && ftype[FTB_PRIV]); // R4

endmodule

// File: rtl/dfj_status.sv
module dfj_status
   import dfj_pkg::*;
#(
   parameter int VA_W  = 64,
   parameter int ASI_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  trap_e            code,
   input  logic [FT_W-1:0]  ftype,
   input  logic [ASI_W-1:0] asi,
   input  logic             is_write,
   input  logic [VA_W-1:0]  va,
   input  logic             sfsr_clr,
   output logic             trap_valid,
   output logic [2:0]       trap_code,
   output logic             sfsr_valid,
   output logic             sfsr_ovw,
   output logic [FT_W-1:0]  sfsr_ftype,
   output logic [ASI_W-1:0] sfsr_asi,
   output logic             sfsr_write,
   output logic [VA_W-1:0]  sfar
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_valid <= 1'b0;
         trap_code  <= T_NONE;
         sfsr_valid <= 1'b0;
         sfsr_ovw   <= 1'b0;
         sfsr_ftype <= '0;
         sfsr_asi   <= '0;
         sfsr_write <= 1'b0;
         sfar       <= '0;
      end else begin
         trap_valid <= fire;
         trap_code  <= fire ? code : T_NONE;
         if (fire) begin
            sfsr_valid <= 1'b1;
            sfsr_ovw   <= sfsr_valid & ~sfsr_clr;
            sfsr_ftype <= ftype;
            sfsr_asi   <= asi;
            sfsr_write <= is_write;
            sfar       <= va;
         end else if (sfsr_clr) begin
            sfsr_valid <= 1'b0;
            sfsr_ovw   <= 1'b0;
         end
      end
   end

   AST_OVW_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sfsr_ovw) |-> $past(sfsr_valid)); // R13

   AST_SFAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(sfar) && $stable(sfsr_ftype)); // R13

   AST_FIRE_LOGS: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> sfsr_valid && trap_valid); // R13

   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (sfsr_clr && !fire) |=> !sfsr_valid && !sfsr_ovw); // R14

endmodule

// File: rtl/dfj_fault_judge.sv
module dfj_fault_judge
   import dfj_pkg::*;
#(
   parameter int VA_W     = 64,
   parameter int PA_W     = 41,
   parameter int HOLE_LSB = 43,
   parameter int ASI_W    = 8,
   parameter bit PA_WATCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [2:0]       acc_kind,
   input  logic [2:0]       acc_size,
   input  logic [ASI_W-1:0] acc_asi,
   input  logic [VA_W-1:0]  acc_va,
   input  logic [PA_W-1:0]  acc_pa,
   input  logic             pg_nfo,
   input  logic             pg_writable,
   input  logic             mmu_on,
   input  logic             st_priv,
   input  logic             st_addr_mask,
   input  logic             dp_ctl,
   input  logic             wp_va_en,
   input  logic [VA_W-1:0]  wp_va,
   input  logic             wp_pa_en,
   input  logic [PA_W-1:0]  wp_pa,
   input  logic             sfsr_clr,
   output logic             trap_valid,
   output logic [2:0]       trap_code,
   output logic             sfsr_valid,
   output logic             sfsr_ovw,
   output logic [FT_W-1:0]  sfsr_ftype,
   output logic [ASI_W-1:0] sfsr_asi,
   output logic             sfsr_write,
   output logic [VA_W-1:0]  sfar
);

   localparam int SZ_W = 3;

   initial begin
      assert (PA_W <= VA_W) else $error("dfj_fault_judge: PA wider than VA");
   end

   acc_kind_e kind;
   assign kind = acc_kind_e'(acc_kind);

   logic is_restricted, is_translated, is_nofault, is_bypass_se, is_regspace, is_valid;
   logic misaligned, va_hole, wp_hit, reg_ro, reg_wo, reg_rw;
   logic fire, is_write;
   trap_e code;
   logic [FT_W-1:0] ftype;

   dfj_asi_dec #(.ASI_W(ASI_W)) u_asi (
      .asi(acc_asi), .is_restricted(is_restricted), .is_translated(is_translated),
      .is_nofault(is_nofault), .is_bypass_se(is_bypass_se),
      .is_regspace(is_regspace), .is_valid(is_valid)
   );

   dfj_addr_chk #(.VA_W(VA_W), .PA_W(PA_W), .HOLE_LSB(HOLE_LSB), .SZ_W(SZ_W),
                  .PA_WATCH(PA_WATCH)) u_addr (
      .kind(kind), .size(acc_size), .va(acc_va), .pa(acc_pa),
      .wp_va_en(wp_va_en), .wp_va(wp_va), .wp_pa_en(wp_pa_en), .wp_pa(wp_pa),
      .misaligned(misaligned), .va_hole(va_hole), .wp_hit(wp_hit),
      .reg_ro(reg_ro), .reg_wo(reg_wo), .reg_rw(reg_rw)
   );

   dfj_cause u_cause (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .kind(kind),
      .mmu_on(mmu_on), .st_priv(st_priv), .st_addr_mask(st_addr_mask),
      .dp_ctl(dp_ctl), .pg_nfo(pg_nfo), .pg_writable(pg_writable),
      .is_restricted(is_restricted), .is_translated(is_translated),
      .is_nofault(is_nofault), .is_bypass_se(is_bypass_se),
      .is_regspace(is_regspace), .is_valid(is_valid),
      .misaligned(misaligned), .va_hole(va_hole), .wp_hit(wp_hit),
      .reg_ro(reg_ro), .reg_wo(reg_wo), .reg_rw(reg_rw),
      .fire(fire), .code(code), .ftype(ftype), .is_write(is_write)
   );

   dfj_status #(.VA_W(VA_W), .ASI_W(ASI_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .fire(fire), .code(code), .ftype(ftype),
      .asi(acc_asi), .is_write(is_write), .va(acc_va), .sfsr_clr(sfsr_clr),
      .trap_valid(trap_valid), .trap_code(trap_code), .sfsr_valid(sfsr_valid),
      .sfsr_ovw(sfsr_ovw), .sfsr_ftype(sfsr_ftype), .sfsr_asi(sfsr_asi),
      .sfsr_write(sfsr_write), .sfar(sfar)
   );

   AST_MIS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && misaligned) |=> trap_valid && trap_code == T_MIS); // R3

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !trap_valid); // R2

endmodule

// File: tb/tb_dfj_fault_judge.sv
module tb_dfj_fault_judge;

   localparam int VA_W = 64;
   localparam int PA_W = 41;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            acc_valid = 1'b0;
   logic [2:0]      acc_kind = 3'd0;
   logic [2:0]      acc_size = 3'd3;
   logic [7:0]      acc_asi = 8'h80;
   logic [VA_W-1:0] acc_va = 64'h1000;
   logic [PA_W-1:0] acc_pa = '0;
   logic pg_nfo, pg_writable, mmu_on, st_priv, st_addr_mask, dp_ctl;
   logic wp_va_en, wp_pa_en, sfsr_clr;
   logic [VA_W-1:0] wp_va;
   logic [PA_W-1:0] wp_pa;
   logic            trap_valid, sfsr_valid, sfsr_ovw, sfsr_write;
   logic [2:0]      trap_code;
   logic [6:0]      sfsr_ftype;
   logic [7:0]      sfsr_asi;
   logic [VA_W-1:0] sfar;

   dfj_fault_judge dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
      .acc_size(acc_size), .acc_asi(acc_asi), .acc_va(acc_va), .acc_pa(acc_pa),
      .pg_nfo(pg_nfo), .pg_writable(pg_writable), .mmu_on(mmu_on),
      .st_priv(st_priv), .st_addr_mask(st_addr_mask), .dp_ctl(dp_ctl),
      .wp_va_en(wp_va_en), .wp_va(wp_va), .wp_pa_en(wp_pa_en), .wp_pa(wp_pa),
      .sfsr_clr(sfsr_clr), .trap_valid(trap_valid), .trap_code(trap_code),
      .sfsr_valid(sfsr_valid), .sfsr_ovw(sfsr_ovw), .sfsr_ftype(sfsr_ftype),
      .sfsr_asi(sfsr_asi), .sfsr_write(sfsr_write), .sfar(sfar)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int              due;
      logic [2:0]      code;
      logic [6:0]      ft;
      logic [VA_W-1:0] va;
      string           tag;
   } exp_t;
   exp_t sb[$];

   localparam logic [2:0] LD = 3'd0, ST = 3'd1, AT = 3'd2, FL = 3'd3, NF = 3'd4, JL = 3'd5;
   localparam logic [2:0] C_NONE = 3'd0, C_MIS = 3'd1, C_PRIV = 3'd2, C_DAE = 3'd3,
                          C_PROT = 3'd4, C_WATCH = 3'd5;

   task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                      input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
         exp_t e;
         e = sb.pop_front();
         chk(trap_valid == (e.code != C_NONE), {e.tag, " valid"},
             64'(trap_valid), 64'(e.code != C_NONE));
         chk(trap_code == e.code, {e.tag, " code"}, 64'(trap_code), 64'(e.code));
         if (e.code != C_NONE) begin
            chk(sfsr_ftype == e.ft, {e.tag, " ftype"}, 64'(sfsr_ftype), 64'(e.ft));
            chk(sfar == e.va, {e.tag, " sfar"}, sfar, e.va);
         end
      end
   end

   task automatic dflt();
      pg_nfo = 0; pg_writable = 1; mmu_on = 1; st_priv = 1; st_addr_mask = 0;
      dp_ctl = 1; wp_va_en = 0; wp_pa_en = 0; wp_va = '0; wp_pa = '0;
      acc_size = 3'd3; acc_pa = 41'h100;
   endtask

   task automatic send(input logic [2:0] k, input logic [7:0] asi,
                       input logic [63:0] va, input logic [2:0] ecode,
                       input logic [6:0] eft, input string tag);
      exp_t e;
      @(negedge clk);
      acc_kind = k; acc_asi = asi; acc_va = va; acc_valid = 1'b1;
      e.due = cyc + 1; e.code = ecode; e.ft = eft; e.va = va; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      sfsr_clr = 1'b1;
      @(negedge clk);
      sfsr_clr = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected below 20000", cyc);
         finish_run();
      end
   end

   initial begin
      sfsr_clr = 0;
      dflt();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!trap_valid, "R1 trap_valid", 64'(trap_valid), 0);
      chk(!sfsr_valid, "R1 sfsr_valid", 64'(sfsr_valid), 0);
      chk(!sfsr_ovw, "R1 sfsr_ovw", 64'(sfsr_ovw), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 clean accesses
      send(LD, 8'h80, 64'h1000, C_NONE, 0, "R2 clean load");
      send(ST, 8'h88, 64'h2008, C_NONE, 0, "R2 clean store");
      @(negedge clk);
      chk(!trap_valid, "R2 idle", 64'(trap_valid), 0);

      // R3 alignment
      send(LD, 8'h80, 64'h1004, C_MIS, 0, "R3 8B at +4");
      acc_size = 3'd4;
      send(AT, 8'h80, 64'h1008, C_MIS, 0, "R3 16B at +8");
      send(LD, 8'h80, 64'h1010, C_NONE, 0, "R3 16B aligned");
      acc_size = 3'd0;
      send(LD, 8'h80, 64'h1003, C_NONE, 0, "R3 byte odd");
      send(JL, 8'h80, 64'h1002, C_MIS, 0, "R3 jmpl +2");
      send(JL, 8'h80, 64'h1004, C_NONE, 0, "R3 jmpl +4");
      send(FL, 8'h80, 64'h1001, C_NONE, 0, "R3 flush odd");
      acc_size = 3'd1; st_priv = 0;
      send(LD, 8'h10, 64'h1001, C_MIS, 0, "R3 mis beats priv");
      dflt();

      // R4 privileged action
      st_priv = 0;
      send(LD, 8'h04, 64'h1000, C_PRIV, 7'h01, "R4 restricted asi");
      send(LD, 8'h20, 64'h1000, C_PRIV, 7'h01, "R4 beats invalid asi");
      send(LD, 8'h80, 64'h1000, C_NONE, 0, "R4 unrestricted ok");
      // R5 invalid ASI
      send(LD, 8'h90, 64'h1000, C_DAE, 7'h08, "R5 bad asi 0x90");
      dflt();
      send(LD, 8'h20, 64'h1000, C_DAE, 7'h08, "R5 bad asi 0x20");

      // R6 register space
      send(LD, 8'h58, 64'h08, C_DAE, 7'h20, "R6 read write-only");
      send(ST, 8'h58, 64'h00, C_DAE, 7'h20, "R6 write read-only");
      send(LD, 8'h58, 64'h00, C_NONE, 0, "R6 read read-only");
      send(ST, 8'h58, 64'h10, C_NONE, 0, "R6 write rw");
      send(LD, 8'h58, 64'h30, C_DAE, 7'h20, "R6 bad offset");

      // R7 no-fault-only page
      pg_nfo = 1;
      send(LD, 8'h80, 64'h1000, C_DAE, 7'h02, "R7 nfo normal asi");
      send(NF, 8'h82, 64'h1000, C_NONE, 0, "R7 nfo nofault asi");
      send(LD, 8'h8B, 64'h1000, C_NONE, 0, "R7 nfo nofault little");
      send(FL, 8'h81, 64'h1000, C_DAE, 7'h02, "R7 nfo flush");
      mmu_on = 0;
      send(LD, 8'h80, 64'h1000, C_NONE, 0, "R7 nfo mmu off");
      dflt();

      // R8 address hole
      send(LD, 8'h80, 64'h0000_1000_0000_0000, C_DAE, 7'h10, "R8 hole");
      send(FL, 8'h80, 64'h0000_1000_0000_0000, C_DAE, 7'h10, "R8 hole flush");
      send(LD, 8'h80, 64'hFFFF_F800_0000_0000, C_NONE, 0, "R8 top edge");
      st_addr_mask = 1;
      send(LD, 8'h80, 64'h0000_1000_0000_0000, C_NONE, 0, "R8 masked");
      dflt();
      pg_nfo = 1;
      send(LD, 8'h80, 64'h0000_1000_0000_0000, C_DAE, 7'h12, "R8 R7 cause or");
      dflt();

      // R9 MMU off speculative / flush
      mmu_on = 0; dp_ctl = 0;
      send(NF, 8'h82, 64'h1000, C_DAE, 7'h40, "R9 spec load");
      send(FL, 8'h80, 64'h1000, C_DAE, 7'h40, "R9 flush");
      send(LD, 8'h80, 64'h1000, C_NONE, 0, "R9 plain load");
      dp_ctl = 1;
      send(NF, 8'h82, 64'h1000, C_NONE, 0, "R9 dp set");
      // R10 atomic bypass with side effect
      send(AT, 8'h15, 64'h1000, C_DAE, 7'h04, "R10 atomic 0x15");
      acc_size = 3'd4;
      send(AT, 8'h1D, 64'h1010, C_DAE, 7'h04, "R10 atomic 16B 0x1D");
      acc_size = 3'd3;
      send(AT, 8'h14, 64'h1000, C_NONE, 0, "R10 plain bypass");
      mmu_on = 1;
      send(AT, 8'h15, 64'h1000, C_NONE, 0, "R10 mmu on");
      dflt();

      // R11 protection
      pg_writable = 0;
      send(ST, 8'h80, 64'h1000, C_PROT, 0, "R11 store");
      send(AT, 8'h81, 64'h1000, C_PROT, 0, "R11 atomic");
      send(LD, 8'h80, 64'h1000, C_NONE, 0, "R11 load");
      pg_nfo = 1;
      send(ST, 8'h80, 64'h1000, C_DAE, 7'h02, "R11 dae beats prot");
      dflt();

      // R12 watchpoints
      wp_va = 64'h3000;
      send(LD, 8'h80, 64'h3000, C_NONE, 0, "R12 va disabled");
      wp_va_en = 1;
      send(LD, 8'h80, 64'h3000, C_WATCH, 0, "R12 va load");
      send(LD, 8'h80, 64'h3008, C_NONE, 0, "R12 va miss");
      send(FL, 8'h80, 64'h3000, C_NONE, 0, "R12 flush ignored");
      pg_writable = 0;
      send(ST, 8'h80, 64'h3000, C_PROT, 0, "R12 prot beats watch");
      dflt();
      wp_pa = 41'h1_2340; acc_pa = 41'h1_2340; wp_pa_en = 1;
      send(ST, 8'h80, 64'h1000, C_WATCH, 0, "R12 pa store");
      dflt();

      // R13/R14 status capture
      pulse_clr();
      chk(!sfsr_valid, "R14 clr valid", 64'(sfsr_valid), 0);
      chk(!sfsr_ovw, "R14 clr ovw", 64'(sfsr_ovw), 0);
      st_priv = 0;
      send(ST, 8'h04, 64'h4000, C_PRIV, 7'h01, "R13 first");
      chk(sfsr_valid, "R13 valid", 64'(sfsr_valid), 1);
      chk(!sfsr_ovw, "R13 no ovw", 64'(sfsr_ovw), 0);
      chk(sfsr_asi == 8'h04, "R13 asi", 64'(sfsr_asi), 64'h04);
      chk(sfsr_write, "R13 write", 64'(sfsr_write), 1);
      dflt();
      send(LD, 8'h81, 64'h4002, C_MIS, 0, "R13 second");
      chk(sfsr_ovw, "R13 ovw", 64'(sfsr_ovw), 1);
      chk(sfsr_asi == 8'h81, "R13 asi2", 64'(sfsr_asi), 64'h81);
      chk(!sfsr_write, "R13 read", 64'(sfsr_write), 0);
      send(ST, 8'h80, 64'h5000, C_NONE, 0, "R13 clean");
      chk(sfar == 64'h4002, "R13 sfar held", sfar, 64'h4002);
      chk(sfsr_asi == 8'h81, "R13 asi held", 64'(sfsr_asi), 64'h81);
      sfsr_clr = 1;
      send(LD, 8'h90, 64'h6000, C_DAE, 7'h08, "R14 clr with fault");
      sfsr_clr = 0;
      chk(sfsr_valid, "R14 fault wins", 64'(sfsr_valid), 1);
      chk(!sfsr_ovw, "R14 no ovw", 64'(sfsr_ovw), 0);

      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R2 scoreboard drained", 64'(sb.size()), 0);
      finish_run();
   end

endmodule